// File: doc/BRIEF.md
# Shared Interrupt Vector Source Aggregator

This block collects peripheral event pulses into a small set of shared interrupt request lines. Each shared vector groups up to eight sources. Every source has a sticky event flag and an enable bit. Any enabled flag that is set raises the vector's request line toward the interrupt controller. Flags latch even when their source is masked, so software can poll events that it chooses not to take as interrupts.

Software reaches each vector through three registers on a simple CPU register bus. A select register reads back the enable mask and the flag bits. A write-only clear register drops individual flags. A control register holds the vector's request bit and one priority field that applies to every source in the group. When the interrupt controller acknowledges a vector, the request bit clears automatically and the source flags are untouched. The service routine then reads the flags, clears the ones it handles, and serves them. An enabled event that arrives while other enabled flags are still pending raises the request again, so no event is lost after an acknowledge. Four vectors are built by default, and each one is fully independent of the others.

Top module: `shirq_top`

## Requirements
- R1: Reading a vector's select register returns the enable mask in bits [15:8] (bit 8+i enables source i) and the event flags in bits [7:0] (bit i is the flag of source i).
- R2: A pulse on a source's event input sets that source's flag at the next clock edge, whether or not the source is enabled.
- R3: A flag clears only when a 1 is written to its bit position in the clear register. Zero bits in a clear write leave flags as they are, and writes to bits [7:0] of the select register never change flags, while bits [15:8] of that write load the enable mask.
- R4: When an event and a clear-register write hit the same flag in the same cycle, the flag ends up set.
- R5: The request line of a vector rises one cycle after a flag becomes both set and enabled. This can happen through a new event on an enabled source, or by enabling a flag that is already set. Flags on masked sources never raise the request.
- R6: An acknowledge pulse clears the vector's request at the next edge and leaves all flags unchanged. If a new enabled flag becomes pending in the same cycle as the acknowledge, the request stays set.
- R7: After an acknowledge, an event on another enabled source raises the request again, even though earlier enabled flags are still pending.
- R8: In the control register, bits [3:0] are a read/write priority that drives the vector's priority output, and bit 7 reads back the request bit. Bus writes do not change bit 7.
- R9: The bus address selects the vector in bits [3:2] and the register in bits [1:0]: 0 is select, 1 is clear, 2 is control. The clear register and register 3 read as zero, and each vector's registers, flags and request are unaffected by traffic to any other vector.
- R10: After reset, all flags, enables, request bits and priority fields are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Vector index in [3:2], register index in [1:0] |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register, combinational |
| srcEvt | input | 32 | Single-cycle event pulses; vector v uses bits [8v+7:8v] |
| irqAck | input | 4 | Acknowledge pulse from the interrupt controller, one bit per vector |
| irqReq | output | 4 | Request line per vector |
| irqPrio | output | 16 | Priority per vector; vector v uses bits [4v+3:4v] |

## Verification
A corrupted flag or enable register shows on the next select-register read, and through the masked OR it shows on the request line one cycle after the edge where it went wrong. A request bit that fails to set, fails to clear on acknowledge, or fails to re-arm on a second enabled event differs from the expected value at the first sample after that edge. Leakage between vectors is caught because every step compares all four request lines and all four priority fields, not only the vector that was driven.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

  localparam int BUS_W = 16;
  localparam int EN_LSB = 8;
  localparam int REQ_BIT = 7;

  localparam logic [1:0] REG_SEL = 2'd0;
  localparam logic [1:0] REG_CLR = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;

  typedef struct packed {
    logic selWr;
    logic clrWr;
    logic ctlWr;
  } shirq_strobe_t;

endpackage

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int ADDR_W = VEC_W + 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busSel,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [NUM_VEC-1:0][NUM_SRC-1:0]   flags,
  input  logic [NUM_VEC-1:0][NUM_SRC-1:0]   ens,
  input  logic [NUM_VEC-1:0]                reqs,
  input  logic [NUM_VEC-1:0][PRIO_W-1:0]    prios,
  output shirq_strobe_t [NUM_VEC-1:0]       strobes,
  output logic [BUS_W-1:0]                  busRdata
);

  logic [VEC_W-1:0] vecIdx;
  logic [1:0]       regIdx;
  logic             wrAccess;

  assign vecIdx   = busAddr[ADDR_W-1:2];
  assign regIdx   = busAddr[1:0];
  assign wrAccess = busSel && busWr;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
    logic hit;
    assign hit = wrAccess && (vecIdx == VEC_W'(v));
    assign strobes[v].selWr = hit && (regIdx == REG_SEL);
    assign strobes[v].clrWr = hit && (regIdx == REG_CLR);
    assign strobes[v].ctlWr = hit && (regIdx == REG_CTL);
  end

  always_comb begin
    busRdata = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (vecIdx == VEC_W'(v)) begin
        case (regIdx)
          REG_SEL: begin
            busRdata[EN_LSB +: NUM_SRC] = ens[v];
            busRdata[0 +: NUM_SRC]      = flags[v];
          end
          REG_CTL: begin
            busRdata[0 +: PRIO_W] = prios[v];
            busRdata[REQ_BIT]     = reqs[v];
          end
          default: busRdata = '0;
        endcase
      end
    end
  end

  // R9: the clear register is write-only and reads back as zero
  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && regIdx == REG_CLR) |-> (busRdata == '0));

  // R9: register index 3 reads back as zero
  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && regIdx == 2'd3) |-> (busRdata == '0));

endmodule

// File: rtl/shirq_dp.sv
module shirq_dp
  import shirq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  shirq_strobe_t      strb,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] srcEvt,
  input  logic               irqAck,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               reqQ,
  output logic [PRIO_W-1:0]  prioQ
);

  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] flagNext;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] newPend;
  logic               reqNext;
  logic [PRIO_W-1:0]  prioNext;

  always_comb begin
    clrMask  = strb.clrWr ? wdata[NUM_SRC-1:0] : '0;
    // an event wins over a clear of the same bit
    flagNext = (flagQ & ~clrMask) | srcEvt;
    enNext   = strb.selWr ? wdata[EN_LSB +: NUM_SRC] : enQ;
    // bits that become set-and-enabled at this edge
    newPend  = flagNext & enNext & ~(flagQ & enQ);
    if (|newPend)     reqNext = 1'b1;
    else if (irqAck)  reqNext = 1'b0;
    else              reqNext = reqQ;
    prioNext = strb.ctlWr ? wdata[PRIO_W-1:0] : prioQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      reqQ  <= 1'b0;
      prioQ <= '0;
    end else begin
      flagQ <= flagNext;
      enQ   <= enNext;
      reqQ  <= reqNext;
      prioQ <= prioNext;
    end
  end

  // R2 and R4: every pulsed source shows a set flag one cycle later
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcEvt != '0) |=> ((flagQ & $past(srcEvt)) == $past(srcEvt)));

  // R3: without a clear write no flag drops
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrWr |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R5: a request only rises while some enabled flag is set
  p_req_needs_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) |-> ((flagQ & enQ) != '0));

  // R6: an acknowledge with no new event or mask change drops the request
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && srcEvt == '0 && !strb.selWr) |=> !reqQ);

  // R8: priority holds unless the control register is written
  p_prio_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctlWr |=> $stable(prioQ));

endmodule

// File: rtl/shirq_top.sv
module shirq_top
  import shirq_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  localparam int ADDR_W = $clog2(NUM_VEC) + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSel,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [BUS_W-1:0]            busWdata,
  output logic [BUS_W-1:0]            busRdata,
  input  logic [NUM_VEC*NUM_SRC-1:0]  srcEvt,
  input  logic [NUM_VEC-1:0]          irqAck,
  output logic [NUM_VEC-1:0]          irqReq,
  output logic [NUM_VEC*PRIO_W-1:0]   irqPrio
);

  shirq_strobe_t [NUM_VEC-1:0]     strobes;
  logic [NUM_VEC-1:0][NUM_SRC-1:0] flags;
  logic [NUM_VEC-1:0][NUM_SRC-1:0] ens;
  logic [NUM_VEC-1:0][PRIO_W-1:0]  prios;

  shirq_ctrl #(
    .NUM_VEC (NUM_VEC),
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .flags    (flags),
    .ens      (ens),
    .reqs     (irqReq),
    .prios    (prios),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    shirq_dp #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W)
    ) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strobes[v]),
      .wdata  (busWdata),
      .srcEvt (srcEvt[v*NUM_SRC +: NUM_SRC]),
      .irqAck (irqAck[v]),
      .flagQ  (flags[v]),
      .enQ    (ens[v]),
      .reqQ   (irqReq[v]),
      .prioQ  (prios[v])
    );
    assign irqPrio[v*PRIO_W +: PRIO_W] = prios[v];
  end

endmodule

// File: tb/shirq_top_bench.sv
`timescale 1ns/100ps
module shirq_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [31:0] srcEvt = '0;
  logic [3:0]  irqAck = '0;
  logic [3:0]  irqReq;
  logic [15:0] irqPrio;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mFlag [4];
  logic [7:0] mEn   [4];
  logic       mReq  [4];
  logic [3:0] mPrio [4];

  always #2.5 clk = ~clk;

  shirq_top u_shirq_top (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .srcEvt   (srcEvt),
    .irqAck   (irqAck),
    .irqReq   (irqReq),
    .irqPrio  (irqPrio)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expReq();
    logic [3:0] r;
    for (int v = 0; v < 4; v++) r[v] = mReq[v];
    return r;
  endfunction

  function automatic logic [15:0] expPrio();
    logic [15:0] p;
    for (int v = 0; v < 4; v++) p[v*4 +: 4] = mPrio[v];
    return p;
  endfunction

  // one clock with the given stimulus; model follows the requirement rules
  task automatic step(input logic [31:0] evt, input logic [3:0] ack, input bit wr,
                      input logic [3:0] addr, input logic [15:0] wd, input string tag);
    @(negedge clk);
    srcEvt = evt; irqAck = ack; busSel = wr; busWr = wr; busAddr = addr; busWdata = wd;
    @(posedge clk);
    for (int v = 0; v < 4; v++) begin
      logic [7:0] fN, eN, clr, np;
      bit hit;
      hit = wr && (addr[3:2] == v[1:0]);
      clr = (hit && addr[1:0] == 2'd1) ? wd[7:0] : 8'h00;
      fN  = (mFlag[v] & ~clr) | evt[v*8 +: 8];
      eN  = (hit && addr[1:0] == 2'd0) ? wd[15:8] : mEn[v];
      np  = fN & eN & ~(mFlag[v] & mEn[v]);
      if (np != 0) mReq[v] = 1'b1;
      else if (ack[v]) mReq[v] = 1'b0;
      if (hit && addr[1:0] == 2'd2) mPrio[v] = wd[3:0];
      mFlag[v] = fN;
      mEn[v] = eN;
    end
    #1;
    srcEvt = '0; irqAck = '0; busSel = 1'b0; busWr = 1'b0;
    chk({28'd0, irqReq}, {28'd0, expReq()}, {tag, " irqReq"});
    chk({16'd0, irqPrio}, {16'd0, expPrio()}, {tag, " irqPrio"});
  endtask

  task automatic idle(input string tag);
    step('0, '0, 1'b0, '0, '0, tag);
  endtask

  task automatic rd(input int v, input logic [1:0] r, input string tag);
    logic [15:0] e;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = {v[1:0], r};
    #1;
    case (r)
      2'd0: e = {mEn[v], mFlag[v]};
      2'd2: e = {8'd0, mReq[v], 3'd0, mPrio[v]};
      default: e = 16'd0;
    endcase
    chk({16'd0, busRdata}, {16'd0, e}, tag);
    busSel = 1'b0;
  endtask

  function automatic logic [3:0] ad(input int v, input logic [1:0] r);
    return {v[1:0], r};
  endfunction

  initial begin
    for (int v = 0; v < 4; v++) begin
      mFlag[v] = 0; mEn[v] = 0; mReq[v] = 0; mPrio[v] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R10: reset state
    chk({28'd0, irqReq}, 32'd0, "R10 irqReq after reset");
    chk({16'd0, irqPrio}, 32'd0, "R10 irqPrio after reset");
    for (int v = 0; v < 4; v++) begin
      rd(v, 2'd0, "R10 select after reset");
      rd(v, 2'd2, "R10 control after reset");
    end

    // R2, R5: masked events latch but never request; R1 layout, R9 independence
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 8; s++) begin
        step(32'd1 << (v*8 + s), '0, 1'b0, '0, '0, "R2 masked event / R5 no request");
        rd(v, 2'd0, "R1 R2 select flags");
      end
      for (int w = 0; w < 4; w++) rd(w, 2'd0, "R9 other vectors untouched");
    end

    // R3: writes to select low byte ignored, high byte loads enables (zero here)
    for (int v = 0; v < 4; v++) begin
      step('0, '0, 1'b1, ad(v, 2'd0), 16'h00_00, "R3 select low byte ignored");
      rd(v, 2'd0, "R3 flags kept after select write");
    end

    // R3: clear register, one bit at a time; zeros leave others alone; R9 clear reads 0
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 8; s++) begin
        step('0, '0, 1'b1, ad(v, 2'd1), 16'h0001 << s, "R3 clear one bit");
        rd(v, 2'd0, "R3 select after clear");
        rd(v, 2'd1, "R9 clear reads zero");
        rd(v, 2'd3, "R9 hole reads zero");
      end
    end

    // R1, R5, R6: per source, enable then event raises request; ack drops it, flags stay
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 8; s++) begin
        step('0, '0, 1'b1, ad(v, 2'd0), 16'h0100 << s, "R1 enable write");
        rd(v, 2'd0, "R1 enable readback");
        step(32'd1 << (v*8 + s), '0, 1'b0, '0, '0, "R5 enabled event raises request");
        rd(v, 2'd2, "R8 request visible in control bit 7");
        step('0, 4'd1 << v, 1'b0, '0, '0, "R6 ack clears request");
        rd(v, 2'd0, "R6 flags unchanged by ack");
        step('0, '0, 1'b1, ad(v, 2'd1), 16'h0001 << s, "R3 clear serviced flag");
      end
      step('0, '0, 1'b1, ad(v, 2'd0), 16'h0000, "R1 disable all");
    end

    // R7: second enabled event while first still pending re-raises after ack
    step('0, '0, 1'b1, ad(1, 2'd0), 16'h0700, "R7 enable three sources");
    step(32'h0000_0400, '0, 1'b0, '0, '0, "R7 first event");
    step('0, 4'b0010, 1'b0, '0, '0, "R7 ack first");
    step(32'h0000_0100, '0, 1'b0, '0, '0, "R7 second event re-raises");
    step('0, 4'b0010, 1'b0, '0, '0, "R7 ack second");
    step(32'h0000_0400, '0, 1'b0, '0, '0, "R7 repeat of pending flag no raise");
    rd(1, 2'd0, "R7 select both flags");

    // R6: new enabled event in same cycle as ack keeps request
    step(32'h0000_0200, 4'b0010, 1'b0, '0, '0, "R6 set wins over ack");
    step('0, 4'b0010, 1'b0, '0, '0, "R6 ack alone then clears");

    // R4: event and clear on same bit
    step(32'h0000_0800, '0, 1'b1, ad(1, 2'd1), 16'h0008, "R4 event beats clear");
    rd(1, 2'd0, "R4 flag stays set");
    step('0, '0, 1'b1, ad(1, 2'd1), 16'h00FF, "R3 clear all");
    rd(1, 2'd0, "R3 all flags cleared");

    // R5: enabling an already set flag raises the request
    step(32'h0010_0000, '0, 1'b0, '0, '0, "R5 masked event on vector 2");
    step('0, '0, 1'b1, ad(2, 2'd0), 16'h1000, "R5 enabling set flag raises");
    step('0, 4'b0100, 1'b0, '0, '0, "R6 ack vector 2");
    step('0, '0, 1'b1, ad(2, 2'd0), 16'h0000, "R5 disable vector 2");

    // R8: priority per vector, bit 7 not writable
    for (int v = 0; v < 4; v++) begin
      for (int p = 0; p < 16; p++) begin
        step('0, '0, 1'b1, ad(v, 2'd2), 16'hFF80 | 16'(p), "R8 priority write");
        rd(v, 2'd2, "R8 control readback");
      end
      step('0, '0, 1'b1, ad(v, 2'd2), 16'(v * 3 + 5), "R8 final priority");
    end
    for (int v = 0; v < 4; v++) rd(v, 2'd2, "R8 R9 control per vector");
    idle("R8 idle");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule